// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, and can pass data between them in either direction. Each side of the block has its own edge-triggered storage register. The A-side register holds a snapshot of the A bus and the B-side register holds a snapshot of the B bus, and each is loaded from its own clock. Each port is split into three signals: an input value, an output value and an output-enable flag. The parent logic therefore builds any tristate drivers itself, and the block contains none.

An active-low enable and a direction input together choose one of three port modes:

- `PORT_ISOLATE`: neither port is driven.
- `PORT_DRIVE_B`: the B port is driven with data from A.
- `PORT_DRIVE_A`: the A port is driven with data from B.

For each direction, a select input picks what the driven port carries. It can be the live value from the opposite bus, passed straight through, or the value held in that direction's register. The registers keep loading whatever the port mode is. This lets a value be captured while the ports are isolated, or while the other direction is driving, and sent out later.

The port mode is decoded combinationally from the reset, enable and direction inputs. There is no mode register, so the only transitions are input changes:

- `PORT_ISOLATE` to `PORT_DRIVE_B` when the enable goes low with direction high.
- `PORT_ISOLATE` to `PORT_DRIVE_A` when the enable goes low with direction low.
- `PORT_DRIVE_B` and `PORT_DRIVE_A` swap when direction toggles.
- Any mode to `PORT_ISOLATE` when the enable goes high or reset is asserted.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab`, the A-side register loads `a_in`.
- R2: On each rising edge of `clk_ba`, the B-side register loads `b_in`. This happens independently of `clk_ab`.
- R3: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R4: While `oe_n` is 0 and `rst_n` is 1, `dir` selects the driven port. With `dir` = 1, `b_oe` = 1 and `a_oe` = 0. With `dir` = 0, `a_oe` = 1 and `b_oe` = 0.
- R5: `a_oe` and `b_oe` are never 1 in the same cycle.
- R6: While `b_oe` = 1, `b_out` carries a value chosen by `sel_ab`. With `sel_ab` = 0 it equals the present `a_in`, in the same cycle. With `sel_ab` = 1 it equals the A-side register.
- R7: While `a_oe` = 1, `a_out` carries a value chosen by `sel_ba`. With `sel_ba` = 0 it equals the present `b_in`, in the same cycle. With `sel_ba` = 1 it equals the B-side register.
- R8: Both registers still load on their clock edges while `oe_n` = 1. Each value loaded this way can later be sent out through the stored path.
- R9: While one port is driven, the register of the other port still loads on its clock edge.
- R10: `rst_n` = 0 works asynchronously. It clears both registers to zero, holds them at zero through clock edges, and forces `a_oe` = `b_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Load clock of the A-side register |
| clk_ba | input | 1 | Load clock of the B-side register |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive B from A, 0: drive A from B |
| sel_ab | input | 1 | B port source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A port source: 0 live B, 1 stored B |
| a_in | input | W (8) | Value present on the A bus |
| b_in | input | W (8) | Value present on the B bus |
| a_out | output | W (8) | Value to drive onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_out | output | W (8) | Value to drive onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
The enables and the live paths are purely combinational. The bench therefore samples them one time unit after it changes the control or data inputs, before the next clock event. A stored value becomes visible at the output in the same time step as the rising edge that loads it, so stored-path checks are taken after the clock pulse has completed. The sweep loads both registers and then changes the live inputs, so every stored-path check can tell the stored value apart from the live one. Reset effects are checked while `rst_n` is still low and again after it is released, with a clock pulse applied during reset.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
    typedef enum logic [1:0] {
        PORT_ISOLATE = 2'd0,
        PORT_DRIVE_B = 2'd1,
        PORT_DRIVE_A = 2'd2
    } port_mode_e;

    localparam int unsigned NUM_DIRS = 2;
    localparam int unsigned DIR_AB   = 0;
    localparam int unsigned DIR_BA   = 1;
endpackage

// File: rtl/regbus_store.sv
module regbus_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/regbus_route.sv
module regbus_route #(
    parameter int unsigned W = 8
) (
    input  logic         use_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    always_comb begin
        if (use_stored) begin
            y = stored;
        end else begin
            y = live;
        end
    end
endmodule

// File: rtl/regbus_mode.sv
module regbus_mode
    import regbus_pkg::*;
(
    input  logic       rst_n,
    input  logic       oe_n,
    input  logic       dir,
    output port_mode_e mode,
    output logic       a_oe,
    output logic       b_oe
);
    // Next-mode decode (no storage: the mode follows its inputs)
    always_comb begin
        if (!rst_n || oe_n) begin
            mode = PORT_ISOLATE;
        end else if (dir) begin
            mode = PORT_DRIVE_B;
        end else begin
            mode = PORT_DRIVE_A;
        end
    end

    // Output decode per mode
    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (mode)
            PORT_ISOLATE: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
            PORT_DRIVE_B: b_oe = 1'b1;
            PORT_DRIVE_A: a_oe = 1'b1;
            default: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [NUM_DIRS-1:0]        dir_clk;
    logic [NUM_DIRS-1:0]        dir_sel;
    logic [NUM_DIRS-1:0][W-1:0] dir_live;
    logic [NUM_DIRS-1:0][W-1:0] dir_stored;
    logic [NUM_DIRS-1:0][W-1:0] dir_route;
    logic [W-1:0]               stored_a;
    logic [W-1:0]               stored_b;
    port_mode_e                 mode;

    assign dir_clk[DIR_AB]  = clk_ab;
    assign dir_clk[DIR_BA]  = clk_ba;
    assign dir_sel[DIR_AB]  = sel_ab;
    assign dir_sel[DIR_BA]  = sel_ba;
    assign dir_live[DIR_AB] = a_in;
    assign dir_live[DIR_BA] = b_in;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        regbus_store #(.W(W)) store_i (
            .clk   (dir_clk[g]),
            .rst_n (rst_n),
            .d     (dir_live[g]),
            .q     (dir_stored[g])
        );
        regbus_route #(.W(W)) route_i (
            .use_stored (dir_sel[g]),
            .live       (dir_live[g]),
            .stored     (dir_stored[g]),
            .y          (dir_route[g])
        );
    end

    regbus_mode mode_i (
        .rst_n (rst_n),
        .oe_n  (oe_n),
        .dir   (dir),
        .mode  (mode),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

    assign stored_a = dir_stored[DIR_AB];
    assign stored_b = dir_stored[DIR_BA];
    assign b_out    = dir_route[DIR_AB];
    assign a_out    = dir_route[DIR_BA];
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
    parameter int unsigned W = 8
) (
    input logic         rst_n,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         oe_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] stored_a,
    input logic [W-1:0] stored_b
);
    AST_CAPT_A: assert property (@(posedge clk_ab) disable iff (!rst_n)
        1'b1 |=> stored_a == $past(a_in)); // R1
    AST_CAPT_B: assert property (@(posedge clk_ba) disable iff (!rst_n)
        1'b1 |=> stored_b == $past(b_in)); // R2
    AST_ISOLATE: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe)); // R3
    AST_ONE_DRIVER: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !(a_oe && b_oe)); // R5
    AST_B_STORED: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (b_oe && sel_ab) |-> b_out == stored_a); // R6
    AST_A_STORED: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (a_oe && sel_ba) |-> a_out == stored_b); // R7

    always @(posedge clk_ab) begin
        if (rst_n === 1'b0) begin
            AST_RST_CLEAR: assert (stored_a == '0 && !a_oe && !b_oe); // R10
        end
    end
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) chk_i (
    .rst_n    (rst_n),
    .clk_ab   (clk_ab),
    .clk_ba   (clk_ba),
    .oe_n     (oe_n),
    .sel_ab   (sel_ab),
    .sel_ba   (sel_ba),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .stored_a (stored_a),
    .stored_b (stored_b)
);

// File: tb/regbus_xcvr_tb_top.sv
`timescale 1ns/1ps
module regbus_xcvr_tb_top;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    logic [W-1:0] mdl_a, mdl_b;
    int           vectors = 0;
    int           miscompares = 0;

    always #2 clk = ~clk; // 250 MHz

    regbus_xcvr #(.W(W)) dut_i (
        .rst_n (rst_n), .clk_ab (clk_ab), .clk_ba (clk_ba),
        .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .b_in (b_in),
        .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic pulse_ab();
        clk_ab = 1'b1; #2; clk_ab = 1'b0; #2;
        if (rst_n) mdl_a = a_in;
    endtask

    task automatic pulse_ba();
        clk_ba = 1'b1; #2; clk_ba = 1'b0; #2;
        if (rst_n) mdl_b = b_in;
    endtask

    task automatic check_ports(input string tag);
        logic xb, xa;
        xb = !oe_n && dir;
        xa = !oe_n && !dir;
        check({tag, " R3/R4 b_oe"}, {7'd0, b_oe}, {7'd0, xb});
        check({tag, " R4 a_oe"}, {7'd0, a_oe}, {7'd0, xa});
        check({tag, " R5 exclusive"}, {7'd0, a_oe & b_oe}, 8'd0);
        if (xb) check({tag, " R6 b_out"}, b_out, sel_ab ? mdl_a : a_in);
        if (xa) check({tag, " R7 a_out"}, a_out, sel_ba ? mdl_b : b_in);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'h3C; b_in = 8'hA5;
        mdl_a = '0; mdl_b = '0;
        #3;
        // Reset state: outputs disabled even with enable asserted (R10)
        check("R10 reset b_oe", {7'd0, b_oe}, 8'd0);
        check("R10 reset a_oe", {7'd0, a_oe}, 8'd0);
        pulse_ab(); pulse_ba();
        rst_n = 1'b1; #1;
        check("R10 stored A zero after reset", b_out, 8'h00);
        dir = 1'b0; #1;
        check("R10 stored B zero after reset", a_out, 8'h00);

        // Sweep: load registers, change live data, then all 16 control combos
        for (int p = 0; p < 8; p++) begin
            logic [W-1:0] av, bv;
            av = 8'(p * 37 + 11);
            bv = 8'hC3 ^ 8'(p * 53);
            a_in = av; b_in = bv; #1;
            // controls left at last combo (oe_n=1): isolation capture (R8)
            if (p != 3) pulse_ab(); // R1
            if (p != 5) pulse_ba(); // R2
            a_in = ~av; b_in = bv + 8'd1;
            for (int c = 0; c < 16; c++) begin
                sel_ab = c[0]; sel_ba = c[1]; dir = c[2]; oe_n = c[3];
                #1;
                check_ports($sformatf("R1/R2/R8 p=%0d c=%0d", p, c));
            end
        end

        // R9: capture B while B->A path idle and B port driven from live A
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; sel_ba = 1'b1;
        a_in = 8'h81; b_in = 8'h7E; #1;
        check("R6 live while driving B", b_out, 8'h81);
        pulse_ba();
        b_in = 8'h00; dir = 1'b0; #1;
        check("R9 B captured while B driven", a_out, 8'h7E);
        // R9: capture A while A port is driven
        a_in = 8'hD2; #1;
        pulse_ab();
        a_in = 8'h11; dir = 1'b1; sel_ab = 1'b1; #1;
        check("R9 A captured while A driven", b_out, 8'hD2);

        // R10: async reset mid-run with a clock edge during reset
        rst_n = 1'b0; #1;
        check("R10 b_oe during reset", {7'd0, b_oe}, 8'd0);
        a_in = 8'hFF; pulse_ab();
        rst_n = 1'b1; #1;
        check("R10 A cleared, edge ignored", b_out, 8'h00);
        dir = 1'b0; #1;
        check("R10 B cleared", a_out, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule